// File: doc/BRIEF.md
# Pin Input Filter and Interrupt Trigger

This block controls one general-purpose pin. The asynchronous pad level first passes through a two-stage synchronizer. It then goes through a debounce filter that is timed by a single-cycle enable pulse, which a 32.768 kHz real-time clock produces in the system clock domain. The filter can run in one of three behaviours:
- Hold a low level: falls pass at once, rises must persist.
- Hold a high level: rises pass at once, falls must persist.
- Drop glitches: both directions must persist.

The filter can also be bypassed. The filter window is a 4-bit multiplier applied to one of four tick sizes.

The filtered level drives a trigger unit. The trigger can be set to rising edge, falling edge, either edge, high level or low level. A matching event sets an interrupt status bit, and that bit drives the interrupt line. Any transition of the filtered level sets a separate wake status bit. Both status bits are cleared by writing 1 to them.

Software reaches the block through a simple register port with one control word and one status word. The control word also sets the pad output driver. The output can be turned off, driven low, or driven high. When the pin is marked open-drain, a request to drive high leaves the pad undriven.

Top module: `pin_filter_irq`

## Requirements
- R1: While reset is low and after it is released, pad_oe, pad_out and irq are 0, and both register words read 0.
- R2: Address 0 holds the control word, read back as written. Its bits are: [1:0] filter mode, [3:2] tick size, [7:4] window count, [10:8] trigger select, [12:11] drive select, [13] open-drain flag. Drive select 0 or 3 gives pad_oe=0. A value of 1 gives pad_oe=1 with pad_out=0. A value of 2 gives pad_oe=1 with pad_out=1.
- R3: With the open-drain flag set, drive select 2 gives pad_oe=0 and pad_out=0. Drive select 1 still drives low.
- R4: With filter mode 0, or with a window count of 0 in any mode, the filtered level follows the synchronized pad with one register of delay. The filtered level is status bit 2.
- R5: Filter mode 1 passes a falling change at once, and passes a rising change only after the pad has stayed high for the whole window.
- R6: Filter mode 2 passes a rising change at once, and passes a falling change only after the pad has stayed low for the whole window.
- R7: Filter mode 3 accepts a change in either direction only after it has lasted the whole window. A shorter pulse leaves the filtered level unchanged.
- R8: The window is the count multiplied by the tick size. Tick size 0, 1, 2 and 3 select 2, 8, 512 and 2048 RTC ticks.
- R9: Trigger select 1, 2 and 3 set interrupt status (status bit 1) on a rising, falling or either filtered edge. The bit stays set until cleared.
- R10: Trigger select 4 (high) and 5 (low) set interrupt status whenever the filtered level matches. After a clear, the bit comes back on the next cycle if the level still matches.
- R11: Trigger select 0, 6 and 7 never set interrupt status.
- R12: Status is at address 1. Writing 1 to bit 0 clears wake status and writing 1 to bit 1 clears interrupt status. Any filtered transition sets wake status. irq equals interrupt status.
- R13: The trigger sees the filtered level, so a pad pulse rejected by the filter raises no interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rtc_tick | input | 1 | Single-cycle enable, one per RTC period |
| pad_in | input | 1 | Asynchronous pad level |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | Register select: 0 control, 1 status |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr |
| pad_out | output | 1 | Pad output value |
| pad_oe | output | 1 | Pad output enable |
| irq | output | 1 | Interrupt line |

## Verification
Pad pulses of two ticks and steady levels of ten ticks are applied under each filter mode. This shows which direction each mode lets through at once and which direction it holds back. Short pulses show that filter mode 3 drops glitches in both directions, and that a dropped glitch never reaches the trigger. Windows of 16 and 2048 ticks are sampled just before and just after they expire, which tells the tick sizes apart. Rising, falling and level pad sequences under every trigger select, each followed by a clear, show that edge status is held until cleared while level status comes back.

// File: rtl/pin_ctl_pkg.sv
// Shared widths, control word layout and tick-size decoding for the pin
// filter block. Assumes the control word fits in the register data width.
package pin_ctl_pkg;

    localparam int DATA_W  = 16;
    localparam int CNT_W   = 4;
    localparam int MAX_SHF = 11;
    localparam int TICK_W  = CNT_W + MAX_SHF + 1;

    typedef enum logic [1:0] {
        FM_BYPASS = 2'd0,
        FM_HOLD_LO = 2'd1,
        FM_HOLD_HI = 2'd2,
        FM_DEGLITCH = 2'd3
    } filt_mode_e;

    typedef enum logic [2:0] {
        TR_OFF  = 3'd0,
        TR_RISE = 3'd1,
        TR_FALL = 3'd2,
        TR_ANY  = 3'd3,
        TR_HIGH = 3'd4,
        TR_LOW  = 3'd5
    } trig_sel_e;

    typedef struct packed {
        logic             od;
        logic [1:0]       drv;
        logic [2:0]       trig;
        logic [CNT_W-1:0] cnt;
        logic [1:0]       unit;
        logic [1:0]       mode;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    // Log2 of the tick size selected by a unit code (2, 8, 512, 2048 ticks).
    function automatic int unsigned unit_shift(input logic [1:0] u);
        case (u)
            2'd0:    return 1;
            2'd1:    return 3;
            2'd2:    return 9;
            default: return MAX_SHF;
        endcase
    endfunction

endpackage

// File: rtl/pin_sync.sv
// Two-flop synchronizer bringing the asynchronous pad level into clk.
// Assumes the pad is slow compared to clk; adds two cycles of latency.
module pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    // Shift the pad level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_async};
    end

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/pin_debounce.sv
// Debounce filter with four behaviours. A change that must be qualified
// has to persist for cnt * 2^shift RTC ticks; the tick counter restarts
// whenever the input returns to the filtered level. Assumes rtc_tick is a
// single-cycle pulse in the clk domain.
module pin_debounce
    import pin_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rtc_tick,
    input  logic             din,
    input  logic [1:0]       mode,
    input  logic [1:0]       unit,
    input  logic [CNT_W-1:0] cnt,
    output logic             filt
);

    logic [TICK_W-1:0] elapsed;
    logic [TICK_W-1:0] target;
    logic [TICK_W-1:0] elapsed_inc;
    logic              bypass;
    logic              pass_now;

    // Window length in ticks and the immediate-pass decision for this input.
    always_comb begin
        target      = TICK_W'(cnt) << unit_shift(unit);
        elapsed_inc = elapsed + 1'b1;
        bypass      = (mode == FM_BYPASS) || (cnt == '0);
        pass_now    = bypass
                    || ((mode == FM_HOLD_LO) && !din)
                    || ((mode == FM_HOLD_HI) && din);
    end

    // Track the accepted level and time pending changes in RTC ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt    <= 1'b0;
            elapsed <= '0;
        end else if (din == filt) begin
            elapsed <= '0;
        end else if (pass_now) begin
            filt    <= din;
            elapsed <= '0;
        end else if (rtc_tick) begin
            if (elapsed_inc >= target) begin
                filt    <= din;
                elapsed <= '0;
            end else begin
                elapsed <= elapsed_inc;
            end
        end
    end

endmodule

// File: rtl/pin_trigger.sv
// Edge/level trigger on the filtered level plus the wake and interrupt
// status bits. An edge hit beats a clear in the same cycle; a level hit
// yields to a clear and returns one cycle later.
module pin_trigger
    import pin_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       filt,
    input  logic [2:0] trig,
    input  logic       clr_wake,
    input  logic       clr_intr,
    output logic       wake_st,
    output logic       intr_st
);

    logic filt_d;
    logic rise;
    logic fall;
    logic edge_hit;
    logic lvl_hit;

    // Decode the selected trigger condition from the filtered level.
    always_comb begin
        rise     = filt & ~filt_d;
        fall     = ~filt & filt_d;
        edge_hit = 1'b0;
        lvl_hit  = 1'b0;
        case (trig)
            TR_RISE: edge_hit = rise;
            TR_FALL: edge_hit = fall;
            TR_ANY:  edge_hit = rise | fall;
            TR_HIGH: lvl_hit  = filt;
            TR_LOW:  lvl_hit  = ~filt;
            default: ;
        endcase
    end

    // Update the delayed level and both status bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_d  <= 1'b0;
            wake_st <= 1'b0;
            intr_st <= 1'b0;
        end else begin
            filt_d  <= filt;
            wake_st <= (wake_st & ~clr_wake) | rise | fall;
            intr_st <= (intr_st & ~clr_intr) | edge_hit | (lvl_hit & ~clr_intr);
        end
    end

endmodule

// File: rtl/pin_regs.sv
// Register port: control word at address 0, write-one-to-clear status at
// address 1. Reads are combinational and have no side effects.
module pin_regs
    import pin_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              wake_st,
    input  logic              intr_st,
    input  logic              filt,
    output logic [DATA_W-1:0] reg_rdata,
    output ctrl_t             cfg,
    output logic              clr_wake,
    output logic              clr_intr
);

    // Hold the control word written by software.
    always_ff @(posedge clk) begin
        if (!rst_n)                   cfg <= '0;
        else if (reg_wr && !reg_addr) cfg <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    // Decode clear strobes and select read data.
    always_comb begin
        clr_wake  = reg_wr && reg_addr && reg_wdata[0];
        clr_intr  = reg_wr && reg_addr && reg_wdata[1];
        reg_rdata = '0;
        if (!reg_addr) reg_rdata[CTRL_W-1:0] = cfg;
        else           reg_rdata[2:0] = {filt, intr_st, wake_st};
    end

endmodule

// File: rtl/pin_filter_irq.sv
// Top of the pin controller: synchronizer, debounce filter, trigger and
// register port, plus the pad output driver. Assumes rtc_tick is
// generated in the clk domain.
module pin_filter_irq
    import pin_ctl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rtc_tick,
    input  logic              pad_in,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pad_out,
    output logic              pad_oe,
    output logic              irq
);

    ctrl_t cfg;
    logic  pad_s;
    logic  filt;
    logic  wake_st;
    logic  intr_st;
    logic  clr_wake;
    logic  clr_intr;

    pin_sync #(.STAGES(2)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(pad_in), .q_sync(pad_s)
    );

    pin_debounce u_deb (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .din(pad_s),
        .mode(cfg.mode), .unit(cfg.unit), .cnt(cfg.cnt), .filt(filt)
    );

    pin_trigger u_trig (
        .clk(clk), .rst_n(rst_n), .filt(filt), .trig(cfg.trig),
        .clr_wake(clr_wake), .clr_intr(clr_intr),
        .wake_st(wake_st), .intr_st(intr_st)
    );

    pin_regs u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .wake_st(wake_st), .intr_st(intr_st),
        .filt(filt), .reg_rdata(reg_rdata), .cfg(cfg),
        .clr_wake(clr_wake), .clr_intr(clr_intr)
    );

    // Pad driver: open-drain pins never drive a high level.
    always_comb begin
        pad_oe  = (cfg.drv == 2'd1) || ((cfg.drv == 2'd2) && !cfg.od);
        pad_out = (cfg.drv == 2'd2) && !cfg.od;
    end

    assign irq = intr_st;

endmodule

// File: rtl/pin_filter_irq_chk.sv
// Property checker for pin_filter_irq, attached with bind.
module pin_filter_irq_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode,
    input logic [3:0] cnt,
    input logic [2:0] trig,
    input logic [1:0] drv,
    input logic       od,
    input logic       pad_s,
    input logic       filt,
    input logic       irq,
    input logic       pad_oe
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> (!irq && !pad_oe));

    // R3
    od_no_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (od && drv == 2'd2) |-> !pad_oe);

    // R4
    bypass_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0 || cnt == 4'd0) |=> (filt == $past(pad_s)));

    // R5
    hold_lo_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd1 && cnt != 4'd0 && !pad_s && filt) |=> !filt);

    // R6
    hold_hi_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd2 && cnt != 4'd0 && pad_s && !filt) |=> filt);

    // R7
    deglitch_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd3 && cnt != 4'd0 && pad_s == filt) |=> $stable(filt));

    // R11
    trig_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((trig == 3'd0 || trig > 3'd5) && !irq) |=> !irq);

endmodule

bind pin_filter_irq pin_filter_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mode(cfg.mode), .cnt(cfg.cnt),
    .trig(cfg.trig), .drv(cfg.drv), .od(cfg.od), .pad_s(pad_s),
    .filt(filt), .irq(irq), .pad_oe(pad_oe)
);

// File: tb/pin_filter_irq_test.sv
module pin_filter_irq_test;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WDOG_CYC   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rtc_tick = 1'b0;
    logic        pad_in = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_addr = 1'b1;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        pad_out;
    logic        pad_oe;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // {open_drain, drive[1:0], expected oe, expected out}
    localparam logic [4:0] OUT_VEC [8] = '{
        5'b0_00_0_0, 5'b0_01_1_0, 5'b0_10_1_1, 5'b0_11_0_0,
        5'b1_00_0_0, 5'b1_01_1_0, 5'b1_10_0_0, 5'b1_11_0_0
    };

    pin_filter_irq uut (
        .clk(clk), .rst_n(rst_n), .rtc_tick(rtc_tick), .pad_in(pad_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // RTC enable: one clk-wide pulse every TICK_DIV cycles.
    initial begin
        forever begin
            repeat (TICK_DIV - 1) @(negedge clk);
            rtc_tick = 1'b1;
            @(negedge clk);
            rtc_tick = 1'b0;
        end
    end

    task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 1'b1;
    endtask

    task automatic rd(input logic a, output logic [15:0] v);
        reg_addr = a;
        #1 v = reg_rdata;
        reg_addr = 1'b1;
    endtask

    function automatic logic [15:0] mk(input int m, input int u, input int c,
                                       input int t, input int dv, input int o);
        return 16'(m) | (16'(u) << 2) | (16'(c) << 4) | (16'(t) << 8)
             | (16'(dv) << 11) | (16'(o) << 13);
    endfunction

    function automatic logic fbit(input logic [15:0] s);
        return s[2];
    endfunction

    logic [15:0] v;

    initial begin
        // R1 reset state
        cyc(5);
        check("R1 oe", {15'd0, pad_oe}, 16'd0);
        check("R1 irq", {15'd0, irq}, 16'd0);
        rd(1'b1, v); check("R1 status", v, 16'd0);
        rd(1'b0, v); check("R1 ctrl", v, 16'd0);
        rst_n = 1'b1;
        cyc(3);
        check("R1 out after release", {14'd0, pad_oe, pad_out}, 16'd0);

        // R2 / R3 output table
        foreach (OUT_VEC[i]) begin
            automatic logic [15:0] w = mk(0, 0, 0, 0, OUT_VEC[i][3:2], OUT_VEC[i][4]);
            wr(1'b0, w);
            rd(1'b0, v); check("R2 readback", v, w);
            check(OUT_VEC[i][4] ? "R3 od drive" : "R2 drive",
                  {14'd0, pad_oe, pad_out}, {14'd0, OUT_VEC[i][1:0]});
        end

        // R4 / R9 / R12 bypass, rising trigger
        wr(1'b0, mk(0, 0, 5, 1, 0, 0));
        pad_in = 1'b1; cyc(5);
        rd(1'b1, v); check("R4 bypass follow", {15'd0, fbit(v)}, 16'd1);
        check("R9 rise irq", {15'd0, irq}, 16'd1);
        check("R12 wake set", {15'd0, v[0]}, 16'd1);
        wr(1'b1, 16'h3); cyc(5);
        rd(1'b1, v); check("R12 w1c", {14'd0, v[1:0]}, 16'd0);
        check("R9 edge stays cleared", {15'd0, irq}, 16'd0);
        pad_in = 1'b0; cyc(5);
        check("R9 rise ignores fall", {15'd0, irq}, 16'd0);
        rd(1'b1, v); check("R12 wake on fall", {15'd0, v[0]}, 16'd1);
        wr(1'b1, 16'h1);

        // R9 falling and both edges
        wr(1'b0, mk(0, 0, 0, 2, 0, 0));
        pad_in = 1'b1; cyc(5);
        check("R9 fall ignores rise", {15'd0, irq}, 16'd0);
        pad_in = 1'b0; cyc(5);
        check("R9 fall irq", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h3);
        wr(1'b0, mk(0, 0, 0, 3, 0, 0));
        pad_in = 1'b1; cyc(5);
        check("R9 any rise", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h3);
        pad_in = 1'b0; cyc(5);
        check("R9 any fall", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h3);

        // R4 count zero bypasses; R11 trigger off
        wr(1'b0, mk(3, 0, 0, 0, 0, 0));
        pad_in = 1'b1; cyc(5);
        rd(1'b1, v); check("R4 count zero", {15'd0, fbit(v)}, 16'd1);
        check("R11 off no irq", {15'd0, irq}, 16'd0);
        wr(1'b0, mk(3, 0, 0, 7, 0, 0));
        pad_in = 1'b0; cyc(5);
        check("R11 code7 no irq", {15'd0, irq}, 16'd0);
        wr(1'b1, 16'h3);

        // R10 level high and low
        wr(1'b0, mk(0, 0, 0, 4, 0, 0));
        pad_in = 1'b1; cyc(5);
        check("R10 high irq", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h2); cyc(1);
        check("R10 high reasserts", {15'd0, irq}, 16'd1);
        pad_in = 1'b0; cyc(5);
        wr(1'b1, 16'h2); cyc(3);
        check("R10 high released", {15'd0, irq}, 16'd0);
        wr(1'b0, mk(0, 0, 0, 5, 0, 0)); cyc(2);
        check("R10 low irq", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h2); cyc(1);
        check("R10 low reasserts", {15'd0, irq}, 16'd1);
        pad_in = 1'b1; cyc(5);
        wr(1'b1, 16'h3); cyc(3);
        check("R10 low released", {15'd0, irq}, 16'd0);

        // R5 hold low: filtered is 1 now, window 3 x 2 ticks
        wr(1'b0, mk(1, 0, 3, 0, 0, 0));
        pad_in = 1'b0; cyc(4);
        rd(1'b1, v); check("R5 fall immediate", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b1; cyc(8);
        rd(1'b1, v); check("R5 short high held", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b0; cyc(4);
        rd(1'b1, v); check("R5 short high dropped", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b1; cyc(40);
        rd(1'b1, v); check("R5 long high accepted", {15'd0, fbit(v)}, 16'd1);

        // R6 hold high
        wr(1'b0, mk(2, 0, 3, 0, 0, 0));
        pad_in = 1'b0; cyc(8);
        rd(1'b1, v); check("R6 short low held", {15'd0, fbit(v)}, 16'd1);
        pad_in = 1'b1; cyc(4);
        pad_in = 1'b0; cyc(40);
        rd(1'b1, v); check("R6 long low accepted", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b1; cyc(4);
        rd(1'b1, v); check("R6 rise immediate", {15'd0, fbit(v)}, 16'd1);

        // R7 drop glitches both ways
        wr(1'b0, mk(3, 0, 3, 0, 0, 0));
        pad_in = 1'b0; cyc(8); pad_in = 1'b1; cyc(8);
        rd(1'b1, v); check("R7 low glitch dropped", {15'd0, fbit(v)}, 16'd1);
        pad_in = 1'b0; cyc(40);
        rd(1'b1, v); check("R7 long low accepted", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b1; cyc(8); pad_in = 1'b0; cyc(8);
        rd(1'b1, v); check("R7 high glitch dropped", {15'd0, fbit(v)}, 16'd0);
        pad_in = 1'b1; cyc(40);
        rd(1'b1, v); check("R7 long high accepted", {15'd0, fbit(v)}, 16'd1);

        // R13 trigger sees filtered level
        wr(1'b0, mk(3, 0, 3, 3, 0, 0));
        wr(1'b1, 16'h3);
        pad_in = 1'b0; cyc(8); pad_in = 1'b1; cyc(10);
        check("R13 glitch no irq", {15'd0, irq}, 16'd0);
        pad_in = 1'b0; cyc(40);
        check("R13 real edge irq", {15'd0, irq}, 16'd1);
        wr(1'b1, 16'h3);

        // R8 window lengths: 2 x 8 ticks, then 1 x 2048 ticks
        wr(1'b0, mk(3, 1, 2, 0, 0, 0));
        pad_in = 1'b1; cyc(48);
        rd(1'b1, v); check("R8 16 ticks not yet", {15'd0, fbit(v)}, 16'd0);
        cyc(32);
        rd(1'b1, v); check("R8 16 ticks done", {15'd0, fbit(v)}, 16'd1);
        wr(1'b0, mk(3, 3, 1, 0, 0, 0));
        pad_in = 1'b0; cyc(7000);
        rd(1'b1, v); check("R8 2048 ticks not yet", {15'd0, fbit(v)}, 16'd1);
        cyc(1400);
        rd(1'b1, v); check("R8 2048 ticks done", {15'd0, fbit(v)}, 16'd0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule